// File: doc/BRIEF.md
# GPIO Port Edge Interrupt Unit

This block is the interrupt front end of one GPIO port. The pin levels arrive already synchronized to the clock. Each pin has a one-bit polarity setting that selects whether the pin watches for a rising edge or a falling edge. A detected edge sets a sticky bit in a pending-event register. The port drives one interrupt line, asserted while any pending event has its enable bit set.

Software uses a small register bus to enable pins, select polarity, acknowledge events and inject test events. To acknowledge, software writes back the value it read from the pending register, because writing a one clears that bit. A separate force register lets test software set pending bits with no pin activity. To catch both edges on a pin, software flips that pin's polarity after each event.

Top module: `gpio_port_irq`

## Requirements
- R1: After synchronous reset, the pending, enable, force and polarity registers all read 0x00 and `irq_o` is low.
- R2: A pin whose polarity bit is 1 sets its pending bit on a 0-to-1 change. A pin whose polarity bit is 0 sets it on a 1-to-0 change. An edge is a difference between the current pin level and the level one clock earlier.
- R3: A pin change in the direction opposite to its polarity bit leaves the pending bit unchanged.
- R4: Writing to offset 0x14 clears every pending bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When a clear and a new set reach the same pending bit in the same cycle, the bit ends up set.
- R6: Pending bits latch whether or not the pin is enabled. `irq_o` goes high one clock after any bit of (pending AND enable) is set, and goes low one clock after that product becomes zero.
- R7: While a bit of the force register (offset 0x1C) is 1, the matching pending bit is set on every cycle, so a clear cannot remove it. Writing 0 to the force register stops the forcing.
- R8: Rewriting the polarity register while the pins hold steady creates no pending event.
- R9: Registers read back one clock after the address is presented: pending at 0x14, enable at 0x18, force at 0x1C and polarity at 0x20. Any other offset reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPIN | Synchronized pin levels |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Byte offset within the port window |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Registered read data for `bus_addr` |
| irq_o | output | 1 | Registered port interrupt |

## Verification
The bench drives mixed polarity patterns and mixed pin transitions in one step, so a design that swapped rising and falling detection, or ignored the polarity bit, reads back the wrong pending mask.

It places a clear and a fresh edge on the same cycle. A design that let the clear win would lose an event.

It clears while forcing is active, and again after forcing is released. A design that forced only once, or kept forcing after a zero write, would read back the wrong value.

It toggles the polarity register with the pins held steady. A detector that compared against the selected edge instead of the sampled level history would then log spurious events.

Finally, it watches `irq_o` against enable and partial clears, to catch an interrupt that ignores the enable mask or that is not registered.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_PEND = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_ENAB = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_FRC  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_POL  = 6'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_ENAB,
    SEL_FRC,
    SEL_POL
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_PEND: decode_ofs = SEL_PEND;
      OFS_ENAB: decode_ofs = SEL_ENAB;
      OFS_FRC:  decode_ofs = SEL_FRC;
      OFS_POL:  decode_ofs = SEL_POL;
      default:  decode_ofs = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pin_edge_det.sv
module pin_edge_det #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] pol_i,
  output logic [NPIN-1:0] hit_o
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_i;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic rise, fall;
    assign rise     = pin_i[i] & ~prev_q[i];
    assign fall     = ~pin_i[i] & prev_q[i];
    assign hit_o[i] = pol_i[i] ? rise : fall;
  end

  AST_STEADY_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (pin_i == $past(pin_i)) |-> (hit_o == '0)); // R8
endmodule

// File: rtl/pend_latch.sv
module pend_latch #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] set_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] pend_o
);
  logic [NPIN-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R5
endmodule

// File: rtl/port_regs.sv
module port_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   wdata_i,
  input  logic [NPIN-1:0]   pend_i,
  output logic [NPIN-1:0]   enab_o,
  output logic [NPIN-1:0]   frc_o,
  output logic [NPIN-1:0]   pol_o,
  output logic [NPIN-1:0]   clr_o,
  output logic [NPIN-1:0]   rdata_o
);
  reg_sel_e        sel;
  logic [NPIN-1:0] rd_mux;

  assign sel   = decode_ofs(addr_i);
  assign clr_o = (wr_i && sel == SEL_PEND) ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      enab_o <= '0;
      frc_o  <= '0;
      pol_o  <= '0;
    end else if (wr_i) begin
      if (sel == SEL_ENAB) enab_o <= wdata_i;
      if (sel == SEL_FRC)  frc_o  <= wdata_i;
      if (sel == SEL_POL)  pol_o  <= wdata_i;
    end
  end

  always_comb begin
    case (sel)
      SEL_PEND: rd_mux = pend_i;
      SEL_ENAB: rd_mux = enab_o;
      SEL_FRC:  rd_mux = frc_o;
      SEL_POL:  rd_mux = pol_o;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  AST_FRC_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel == SEL_FRC && wdata_i == '0) |=> (frc_o == '0)); // R7
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  output logic              irq_o
);
  logic [NPIN-1:0] hit, pend, enab, frc, pol, clr, set_bits;

  pin_edge_det #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst(rst), .pin_i(pin_i), .pol_i(pol), .hit_o(hit)
  );

  assign set_bits = hit | frc;

  pend_latch #(.NPIN(NPIN)) u_pend (
    .clk(clk), .rst(rst), .set_i(set_bits), .clr_i(clr), .pend_o(pend)
  );

  port_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .pend_i(pend), .enab_o(enab), .frc_o(frc),
    .pol_o(pol), .clr_o(clr), .rdata_o(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(pend & enab);
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(pend & enab)) |=> irq_o); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((pend & enab) == '0) |=> !irq_o); // R6
  AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((pend & $past(hit)) == $past(hit))); // R2
endmodule

// File: tb/gpio_port_irq_test.sv
module gpio_port_irq_test;
  localparam int NPIN = 8;
  localparam logic [5:0] A_PEND = 6'h14, A_ENAB = 6'h18, A_FRC = 6'h1C, A_POL = 6'h20;

  logic clk = 0, rst = 1;
  logic [NPIN-1:0] pin_i = '0, bus_wdata = '0;
  logic bus_wr = 0;
  logic [5:0] bus_addr = '0;
  logic [NPIN-1:0] bus_rdata;
  logic irq_o;
  int checks = 0, fails = 0;
  logic [NPIN-1:0] rv;

  always #4 clk = ~clk;

  gpio_port_irq #(.NPIN(NPIN)) uut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // fields: polarity, pins before, pins after, expected pending
  localparam logic [31:0] VEC [8] = '{
    {8'hFF, 8'h00, 8'hFF, 8'hFF},
    {8'hFF, 8'hFF, 8'h00, 8'h00},
    {8'h00, 8'hFF, 8'h00, 8'hFF},
    {8'h00, 8'h00, 8'hFF, 8'h00},
    {8'h0F, 8'h00, 8'hFF, 8'h0F},
    {8'h0F, 8'hFF, 8'h00, 8'hF0},
    {8'hA5, 8'h5A, 8'hA5, 8'hFF},
    {8'h3C, 8'h33, 8'hCC, 8'h0F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    // R1 reset state
    chk("R1 irq", irq_o, 0);
    rd(A_PEND, rv); chk("R1 pend", rv, 0);
    rd(A_ENAB, rv); chk("R1 enab", rv, 0);
    rd(A_FRC,  rv); chk("R1 frc", rv, 0);
    rd(A_POL,  rv); chk("R1 pol", rv, 0);

    // R2 R3 table walk, interrupts disabled
    foreach (VEC[k]) begin
      wr(A_POL, VEC[k][31:24]);
      @(negedge clk); pin_i = VEC[k][23:16];
      idle(2);
      wr(A_PEND, 8'hFF);
      pin_i = VEC[k][15:8];
      idle(2);
      rd(A_PEND, rv);
      chk($sformatf("R2/R3 vector %0d", k), rv, VEC[k][7:0]);
      chk("R6 irq stays low while disabled", irq_o, 0);
      wr(A_PEND, 8'hFF);
    end

    // R9 readback and unmapped offset
    wr(A_ENAB, 8'h00);
    wr(A_POL, 8'h69); rd(A_POL, rv); chk("R9 pol readback", rv, 8'h69);
    rd(6'h00, rv); chk("R9 unmapped", rv, 0);
    rd(6'h24, rv); chk("R9 unmapped high", rv, 0);

    // R8 polarity rewrite with pins steady
    @(negedge clk); pin_i = 8'hF0; idle(2);
    wr(A_PEND, 8'hFF);
    wr(A_POL, 8'hFF); wr(A_POL, 8'h00); wr(A_POL, 8'h5A); idle(2);
    rd(A_PEND, rv); chk("R8 no spurious event", rv, 0);

    // R6 latch while disabled, then enable
    wr(A_POL, 8'h00);
    @(negedge clk); pin_i = 8'h00; idle(2);   // falling on F0 bits
    rd(A_PEND, rv); chk("R6 latched while disabled", rv, 8'hF0);
    chk("R6 irq low", irq_o, 0);
    wr(A_ENAB, 8'h10); @(negedge clk);
    chk("R6 irq high after enable", irq_o, 1);
    rd(A_ENAB, rv); chk("R9 enab readback", rv, 8'h10);

    // R4 partial clear and zero write
    wr(A_PEND, 8'h00); rd(A_PEND, rv); chk("R4 zero write keeps", rv, 8'hF0);
    wr(A_PEND, 8'h10); rd(A_PEND, rv); chk("R4 partial clear", rv, 8'hE0);
    chk("R6 irq low after clear", irq_o, 0);
    wr(A_PEND, 8'hFF); wr(A_ENAB, 8'h00);

    // R7 force
    wr(A_FRC, 8'h81); rd(A_FRC, rv); chk("R9 frc readback", rv, 8'h81);
    wr(A_PEND, 8'hFF); rd(A_PEND, rv); chk("R7 force survives clear", rv, 8'h81);
    wr(A_FRC, 8'h00); wr(A_PEND, 8'hFF);
    rd(A_PEND, rv); chk("R7 force released", rv, 0);

    // R5 clear and new edge in the same cycle
    wr(A_POL, 8'h01);
    @(negedge clk);
    bus_wr = 1; bus_addr = A_PEND; bus_wdata = 8'h01; pin_i = 8'h01;
    @(negedge clk); bus_wr = 0;
    rd(A_PEND, rv); chk("R5 set wins", rv, 8'h01);

    // R1 reset again clears state
    @(negedge clk); rst = 1; idle(2); rst = 0; pin_i = 8'h01;
    rd(A_PEND, rv); chk("R1 pend after re-reset", rv, 0);
    rd(A_POL, rv); chk("R1 pol after re-reset", rv, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule